// File: doc/BRIEF.md
# Wait-State Bus Cycle Controller

This block sits between a processor core and an external 8-bit-data, 16-bit-address parallel bus. The core asks for one transfer at a time through a simple request port. The block then runs the transfer as a fixed sequence of bus phases. First comes an address phase (T1). Next comes a strobe phase (T2). Zero or more wait phases (Tw) may follow. The transfer closes with a final phase (T3). On reads, the data bus is sampled when T3 ends.

The address picks one of three regions: ROM, RAM and a peripheral window. Each region has its own chip enable and its own programmed number of wait phases. A slow device can also stretch a transfer by holding the WAIT input high. The controller then inserts whichever is larger: the programmed wait count or the number of consecutive cycles WAIT is sampled high. Writes follow the same phases. The controller drives write data and raises an output-enable flag for the whole time it owns the data bus.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request, every chip enable, `bus_rd_n` and `bus_wr_n` is high, and `req_done` and `bus_dout_oe` are low.
- R2: In the cycle after a request is accepted (T1), `bus_addr` shows the request address and the region's chip enable is low, but `bus_rd_n` and `bus_wr_n` are still high. `bus_addr` stays the same until the transfer ends.
- R3: On a read, `bus_rd_n` is low from T2 through T3. `req_rdata` takes the value on `bus_din` at the clock edge that ends T3.
- R4: On a write, `bus_wr_n` is low from T2 through T3, and `bus_rd_n` stays high. `bus_dout_oe` is high and `bus_dout` carries the write data from T1 through T3. `bus_rd_n` and `bus_wr_n` are never low together.
- R5: Address decoding follows the top address bits:
  - 0x0000–0x7FFF selects `bus_ce_n[0]` (ROM).
  - 0x8000–0xDFFF selects `bus_ce_n[1]` (RAM).
  - 0xE000–0xFFFF selects `bus_ce_n[2]` (peripherals).
  
  At most one chip enable is low at any time, and none is low while idle.
- R6: Each region inserts a programmed number of Tw phases between T2 and T3. The defaults are ROM 2, RAM 0 and peripherals 1.
- R7: `bus_wait` is sampled at the edges that end T2 and each Tw. If it is high at k consecutive such samples, the transfer has max(programmed, k) Tw phases. `bus_wait` during T1 or idle has no effect.
- R8: `req_done` is high for exactly one cycle. That cycle begins at the edge that ends T3, which is 3 + Tw clock edges after the accepting edge. In that cycle all strobes and chip enables are already high.
- R9: A `req_start` seen while a transfer is in progress is ignored. It neither changes `bus_addr` nor starts another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | Request a transfer; accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data captured at end of T3 |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data driven toward the bus |
| bus_dout_oe | output | 1 | High while the controller owns the data bus |
| bus_din | input | 8 | Data sampled from the bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ce_n | output | 3 | Active-low chip enables {peripheral, RAM, ROM} |
| bus_wait | input | 1 | Device stretch request, high = wait |

## Verification
The bench uses the default parameters: a 3-bit wait counter, two programmed waits for ROM, none for RAM and one for peripherals. These values exercise the direct T2-to-T3 path, a single wait phase and a multi-phase programmed wait.

Random WAIT stretches of up to four cycles are mixed across all three regions. Some are shorter than the programmed count and some are longer, so the max() rule is tested from both sides.

Directed cases cover:
- the region boundary addresses,
- a WAIT pulse placed in T1,
- a start request placed in the middle of a transfer.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } phase_t;

  localparam int unsigned NUM_REGIONS = 3;

  typedef enum logic [1:0] {
    RG_ROM = 2'd0,
    RG_RAM = 2'd1,
    RG_IO  = 2'd2
  } region_t;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WAIT_W    = 3,
  parameter int unsigned ROM_WAITS = 2,
  parameter int unsigned RAM_WAITS = 0,
  parameter int unsigned IO_WAITS  = 1
) (
  input  logic [ADDR_W-1:0]      addr_i,
  output region_t                region_o,
  output logic [NUM_REGIONS-1:0] hit_o,
  output logic [WAIT_W-1:0]      waits_o
);

  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    if (!addr_i[TOP]) begin
      region_o = RG_ROM;
    end else if (addr_i[TOP-1] && addr_i[TOP-2]) begin
      region_o = RG_IO;
    end else begin
      region_o = RG_RAM;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
    assign hit_o[g] = (int'(region_o) == g);
  end

  always_comb begin
    unique case (region_o)
      RG_ROM:  waits_o = WAIT_W'(ROM_WAITS);
      RG_RAM:  waits_o = WAIT_W'(RAM_WAITS);
      default: waits_o = WAIT_W'(IO_WAITS);
    endcase
  end

endmodule

// File: rtl/bcc_wait_ctr.sv
module bcc_wait_ctr #(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec_en,
  output logic [WAIT_W-1:0] cnt_o,
  output logic              zero_o
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = load_en | dec_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (dec_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   wait_i,
  input  logic   zero_i,
  output phase_t phase_o,
  output logic   accept_o,
  output logic   load_o,
  output logic   dec_o,
  output logic   capture_o,
  output logic   done_o
);

  phase_t phase_q, phase_d;
  logic   done_q, done_d;
  logic   stretch;

  assign stretch = (!zero_i) || wait_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = stretch ? PH_TW : PH_T3;
      PH_TW:   phase_d = stretch ? PH_TW : PH_T3;
      PH_T3:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign accept_o  = (phase_q == PH_IDLE) && start_i;
  assign load_o    = (phase_q == PH_T1);
  assign dec_o     = (phase_q == PH_T2) || (phase_q == PH_TW);
  assign capture_o = (phase_q == PH_T3);
  assign done_d    = capture_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase_q == PH_IDLE)); // R8
  AST_T2_AFTER_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T2) |-> ($past(phase_q) == PH_T1)); // R3

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WAIT_W    = 3,
  parameter int unsigned ROM_WAITS = 2,
  parameter int unsigned RAM_WAITS = 0,
  parameter int unsigned IO_WAITS  = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_start,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_done,
  output logic [DATA_W-1:0]      req_rdata,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   bus_dout_oe,
  input  logic [DATA_W-1:0]      bus_din,
  output logic                   bus_rd_n,
  output logic                   bus_wr_n,
  output logic [NUM_REGIONS-1:0] bus_ce_n,
  input  logic                   bus_wait
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  phase_t                 phase;
  logic                   accept, load, dec, capture, done;
  logic                   wait_zero;
  logic [WAIT_W-1:0]      wait_cnt;
  logic [WAIT_W-1:0]      region_waits;
  logic [NUM_REGIONS-1:0] hit;
  region_t                region;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q;

  bcc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (req_start),
    .wait_i    (bus_wait),
    .zero_i    (wait_zero),
    .phase_o   (phase),
    .accept_o  (accept),
    .load_o    (load),
    .dec_o     (dec),
    .capture_o (capture),
    .done_o    (done)
  );

  bcc_decode #(
    .ADDR_W    (ADDR_W),
    .WAIT_W    (WAIT_W),
    .ROM_WAITS (ROM_WAITS),
    .RAM_WAITS (RAM_WAITS),
    .IO_WAITS  (IO_WAITS)
  ) u_decode (
    .addr_i   (addr_q),
    .region_o (region),
    .hit_o    (hit),
    .waits_o  (region_waits)
  );

  bcc_wait_ctr #(
    .WAIT_W (WAIT_W)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (load),
    .load_val (region_waits),
    .dec_en   (dec),
    .cnt_o    (wait_cnt),
    .zero_o   (wait_zero)
  );

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  // read data capture at the edge closing T3
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else if (capture && !write_q) begin
      rdata_q <= bus_din;
    end
  end

  logic active, strobe;
  assign active = (phase != PH_IDLE);
  assign strobe = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);

  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_oe = active & write_q;
  assign bus_rd_n    = ~(strobe & ~write_q);
  assign bus_wr_n    = ~(strobe & write_q);
  assign bus_ce_n    = ~(hit & {NUM_REGIONS{active}});
  assign req_done    = done;
  assign req_rdata   = rdata_q;

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(~bus_ce_n) <= 1); // R5
  AST_NO_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_IDLE) |-> (&bus_ce_n)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!bus_rd_n && !bus_wr_n)); // R4
  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_dout_oe |-> bus_rd_n); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase != PH_IDLE && phase != PH_T1) |-> $stable(bus_addr)); // R2
  AST_TW_EXIT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(phase) == PH_TW && phase == PH_T3) |-> wait_zero); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (active && req_start) |=> $stable(bus_addr)); // R9

endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_done;
  logic [7:0]  req_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_dout_oe;
  logic [7:0]  bus_din;
  logic        bus_rd_n, bus_wr_n;
  logic [2:0]  bus_ce_n;
  logic        bus_wait;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_done    (req_done),
    .req_rdata   (req_rdata),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_dout_oe (bus_dout_oe),
    .bus_din     (bus_din),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_ce_n    (bus_ce_n),
    .bus_wait    (bus_wait)
  );

  function automatic logic [2:0] exp_ce_n(input logic [15:0] a);
    if (!a[15])            return 3'b110;
    if (a[15:13] == 3'b111) return 3'b011;
    return 3'b101;
  endfunction

  function automatic int prog_waits(input logic [15:0] a);
    if (!a[15])            return 2;
    if (a[15:13] == 3'b111) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one transfer; k = WAIT samples high from T2 on, t1w = WAIT high during T1,
  // poke = extra start with another address during T2
  task automatic run_txn(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                         input logic [7:0] di, input int k, input logic t1w, input logic poke);
    int pw = prog_waits(a);
    int tw = (k > pw) ? k : pw;
    @(negedge clk);
    req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    bus_din = di; bus_wait = 1'b0;
    @(posedge clk);
    for (int c = 0; c <= 3 + tw; c++) begin
      @(negedge clk);
      req_start = poke && (c == 1);
      req_addr  = (poke && c == 1) ? ~a : a;
      bus_wait  = (c == 0) ? t1w : ((c >= 1 && c <= k) ? 1'b1 : 1'b0);
      if (c < 3 + tw) begin
        chk("R5 chip enable", {29'd0, bus_ce_n}, {29'd0, exp_ce_n(a)});
        chk(poke ? "R9 address kept" : "R2 address", {16'd0, bus_addr}, {16'd0, a});
        chk("R8 no early done", {31'd0, req_done}, 32'd0);
        chk("R4 data enable", {31'd0, bus_dout_oe}, {31'd0, wr});
        if (wr) chk("R4 write data", {24'd0, bus_dout}, {24'd0, wd});
      end
      if (c == 0) begin
        chk("R2 strobes idle in T1", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
      end else if (c <= 2 + tw) begin
        if (wr) chk("R4 write strobes", {30'd0, bus_rd_n, bus_wr_n}, 32'd2);
        else    chk("R3 read strobes",  {30'd0, bus_rd_n, bus_wr_n}, 32'd1);
      end else begin
        chk("R8 done pulse (R6 R7 length)", {31'd0, req_done}, 32'd1);
        chk("R8 released", {27'd0, bus_ce_n, bus_rd_n, bus_wr_n}, 32'h1F);
        chk("R4 data enable off", {31'd0, bus_dout_oe}, 32'd0);
        if (!wr) chk("R3 read data", {24'd0, req_rdata}, {24'd0, di});
      end
    end
    req_start = 1'b0; bus_wait = 1'b0;
    @(negedge clk);
    chk("R9 no extra transfer", {28'd0, req_done, bus_ce_n}, 32'h7);
  endtask

  initial begin
    void'($urandom(32'h1D2C3B4A));
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; bus_din = '0; bus_wait = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset strobes", {27'd0, bus_ce_n, bus_rd_n, bus_wr_n}, 32'h1F);
    chk("R1 reset done/oe", {30'd0, req_done, bus_dout_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {29'd0, bus_ce_n}, 32'd7);

    // directed corners
    run_txn(1'b0, 16'h0000, 8'h00, 8'hA5, 0, 1'b0, 1'b0); // R6 ROM 2 waits
    run_txn(1'b0, 16'h7FFF, 8'h00, 8'h5A, 0, 1'b0, 1'b0); // R5 boundary
    run_txn(1'b0, 16'h8000, 8'h00, 8'h3C, 0, 1'b0, 1'b0); // R6 RAM 0 waits
    run_txn(1'b1, 16'hDFFF, 8'hC3, 8'h00, 0, 1'b0, 1'b0); // R5 boundary
    run_txn(1'b1, 16'hE000, 8'h96, 8'h00, 0, 1'b0, 1'b0); // R6 IO 1 wait
    run_txn(1'b0, 16'hFFFF, 8'h00, 8'h69, 0, 1'b0, 1'b0);
    run_txn(1'b0, 16'h9000, 8'h00, 8'h11, 3, 1'b0, 1'b0); // R7 wait stretch
    run_txn(1'b0, 16'h1234, 8'h00, 8'h22, 1, 1'b0, 1'b0); // R7 k below programmed
    run_txn(1'b1, 16'h4000, 8'h77, 8'h00, 4, 1'b0, 1'b0); // R7 k above programmed
    run_txn(1'b0, 16'hA000, 8'h00, 8'h33, 0, 1'b1, 1'b0); // R7 WAIT in T1 ignored
    run_txn(1'b0, 16'hF00F, 8'h00, 8'h44, 2, 1'b0, 1'b1); // R9 start while busy

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a  = 16'($urandom);
      logic        w  = 1'($urandom);
      logic [7:0]  wd = 8'($urandom);
      logic [7:0]  di = 8'($urandom);
      int          k  = (($urandom % 3) == 0) ? int'($urandom % 5) : 0;
      logic        t1 = (($urandom % 6) == 0);
      logic        pk = (($urandom % 8) == 0);
      run_txn(w, a, wd, di, k, t1, pk);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule